// File: doc/BRIEF.md
# Completion Event Ring Producer

This block is the device-side writer of a circular completion ring that lives in a memory shared with a host. Each event arriving on a valid/ready input is written into the ring slot addressed by the producer pointer. Once the memory acknowledges the write, the producer pointer moves on by one and the block raises a one-cycle interrupt toward the host. The host consumes events at its own pace. It returns slots by writing a new value of its own pointer into a doorbell port.

The ring uses a swapped occupancy rule. The device produces at the "read" pointer and the host frees slots by moving the "write" pointer. The ring therefore holds nothing when the write pointer plus one equals the read pointer, and it is full when the two are equal. A ring of `ring_len` slots holds at most `ring_len - 1` pending events. When the ring is full, the event input is held off with ready low until a doorbell frees space. Both pointers wrap at the programmed length, which need not be a power of two.

The control path is a three-state machine:
- `ST_IDLE` waits for an event, with ready equal to "not full".
- `ST_WRITE` drives the memory write until it is acknowledged.
- `ST_NOTIFY` issues the interrupt pulse.

The transitions are:
- IDLE→WRITE when an event is accepted.
- WRITE→WRITE while no acknowledge has come.
- WRITE→NOTIFY on the acknowledge.
- NOTIFY→IDLE always.

Top module: `evt_ring_producer`

## Requirements
- R1: During and right after a synchronous active-low reset, the pointers are set as follows: `rd_ptr` = 0, `wr_ptr` = `ring_len`-1, `ring_empty` = 1, `ring_full` = 0, `irq` = 0, `mem_we` = 0 and `evt_ready` = 1.
- R2: `ring_empty` is 1 exactly when `wr_ptr`+1, taken modulo `ring_len`, equals `rd_ptr`. `ring_full` is 1 exactly when `rd_ptr` equals `wr_ptr`.
- R3: An accepted event's payload is written with `mem_we` = 1 at `mem_addr` equal to the value `rd_ptr` had at acceptance. `mem_we`, `mem_addr` and `mem_wdata` hold steady until the cycle in which `mem_ack` = 1.
- R4: At the clock edge that samples `mem_we` and `mem_ack` both high, `rd_ptr` advances by one modulo `ring_len`. `last_ptr` always equals `rd_ptr`-1 modulo `ring_len`, which is the slot of the most recent event.
- R5: `irq` is high for exactly one cycle per event, in the cycle directly after the acknowledge edge.
- R6: While `ring_full` = 1, `evt_ready` is 0 and no memory write starts. Acceptance resumes once a doorbell frees a slot.
- R7: A doorbell (`db_valid` = 1) whose `db_wp` is less than `ring_len` loads `wr_ptr` at the next edge. A doorbell whose value is `ring_len` or more is ignored and leaves `wr_ptr` unchanged.
- R8: Both pointers wrap from `ring_len`-1 to 0, including for lengths that are not powers of two.
- R9: Only one event is in flight at a time. `evt_ready` is 0 from the acceptance edge until the interrupt cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_len | input | PTR_W | Number of ring slots, at least 2, held static |
| evt_valid | input | 1 | Event offered |
| evt_data | input | DATA_W | Event payload word |
| evt_ready | output | 1 | Event accepted when high together with valid |
| db_valid | input | 1 | Host doorbell write strobe |
| db_wp | input | PTR_W | New host pointer value |
| mem_we | output | 1 | Ring memory write request |
| mem_addr | output | PTR_W | Ring slot index being written |
| mem_wdata | output | DATA_W | Payload being written |
| mem_ack | input | 1 | Memory accepted the write |
| irq | output | 1 | One-cycle interrupt pulse to host |
| rd_ptr | output | PTR_W | Device producer pointer |
| wr_ptr | output | PTR_W | Host-owned pointer copy |
| last_ptr | output | PTR_W | Slot of the last posted event |
| ring_full | output | 1 | Ring full of events |
| ring_empty | output | 1 | No pending events |

## Verification
An event accepted at edge k drives `mem_we` from the cycle after k. The bench memory acknowledges it one edge later. `rd_ptr` moves and `irq` rises at the following edge, so `irq` is sampled exactly two falling edges after the acceptance falling edge, and is required low one edge after that. A doorbell is sampled on the first falling edge after its strobe edge. All checks sample on falling edges and count them, so the cycle in which a result appears is itself part of what is checked.

// File: rtl/evr_pkg.sv
package evr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_NOTIFY = 2'd2
    } evr_state_e;
endpackage

// File: rtl/evr_ptr_unit.sv
module evr_ptr_unit #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] ring_len,
    input  logic             adv,
    input  logic             db_valid,
    input  logic [PTR_W-1:0] db_wp,
    output logic [PTR_W-1:0] rp,
    output logic [PTR_W-1:0] wp,
    output logic [PTR_W-1:0] last,
    output logic             full,
    output logic             empty
);
    logic [PTR_W-1:0] top_idx;
    logic [PTR_W-1:0] rp_next;
    logic [PTR_W-1:0] wp_succ;
    logic             db_ok;

    assign top_idx = ring_len - 1'b1;
    assign rp_next = (rp == top_idx) ? '0 : rp + 1'b1;
    assign wp_succ = (wp == top_idx) ? '0 : wp + 1'b1;
    assign last    = (rp == '0) ? top_idx : rp - 1'b1;
    assign db_ok   = db_valid && (db_wp < ring_len);
    assign full    = (rp == wp);
    assign empty   = (wp_succ == rp);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp <= '0;
        end else if (adv) begin
            rp <= rp_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= top_idx;
        end else if (db_ok) begin
            wp <= db_wp;
        end
    end

    // R4: the producer pointer moves only on an advance request
    assert_rp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(rp));
    // R7: an out-of-range or absent doorbell leaves the host pointer alone
    assert_db_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!db_valid || (db_wp >= ring_len)) |=> $stable(wp));
    // R7: an in-range doorbell is loaded
    assert_db_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (db_valid && (db_wp < ring_len)) |=> (wp == $past(db_wp)));
    // R2: full and empty exclude each other for a legal length
    assert_full_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_len >= 2) |-> !(full && empty));
    // R8: pointers stay inside the ring
    assert_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_len >= 2) |-> ((rp < ring_len) && (wp < ring_len)));
endmodule

// File: rtl/evr_ctrl.sv
module evr_ctrl
    import evr_pkg::*;
#(
    parameter int PTR_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [DATA_W-1:0] evt_data,
    output logic              evt_ready,
    input  logic              full,
    input  logic [PTR_W-1:0]  rp,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    output logic              adv,
    output logic              irq
);
    evr_state_e        state, state_nx;
    logic [DATA_W-1:0] data_q;
    logic [PTR_W-1:0]  slot_q;
    logic              take;

    assign take = evt_valid && evt_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (take) state_nx = ST_WRITE;
            ST_WRITE:  if (mem_ack) state_nx = ST_NOTIFY;
            ST_NOTIFY: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            slot_q <= '0;
        end else if (take) begin
            data_q <= evt_data;
            slot_q <= rp;
        end
    end

    always_comb begin
        evt_ready = 1'b0;
        mem_we    = 1'b0;
        adv       = 1'b0;
        irq       = 1'b0;
        unique case (state)
            ST_IDLE:   evt_ready = !full;
            ST_WRITE: begin
                mem_we = 1'b1;
                adv    = mem_ack;
            end
            ST_NOTIFY: irq = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr  = slot_q;
    assign mem_wdata = data_q;

    // R3: request and its address/data hold until acknowledged
    assert_we_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));
    // R5: the interrupt never lasts two cycles
    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R9: nothing accepted while a write is pending
    assert_one_inflight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || irq) |-> !evt_ready);
endmodule

// File: rtl/evt_ring_producer.sv
module evt_ring_producer #(
    parameter int PTR_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  ring_len,
    input  logic              evt_valid,
    input  logic [DATA_W-1:0] evt_data,
    output logic              evt_ready,
    input  logic              db_valid,
    input  logic [PTR_W-1:0]  db_wp,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    output logic              irq,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  last_ptr,
    output logic              ring_full,
    output logic              ring_empty
);
    logic adv;

    evr_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ring_len (ring_len),
        .adv      (adv),
        .db_valid (db_valid),
        .db_wp    (db_wp),
        .rp       (rd_ptr),
        .wp       (wr_ptr),
        .last     (last_ptr),
        .full     (ring_full),
        .empty    (ring_empty)
    );

    evr_ctrl #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_data  (evt_data),
        .evt_ready (evt_ready),
        .full      (ring_full),
        .rp        (rd_ptr),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .adv       (adv),
        .irq       (irq)
    );

    // R5: the acknowledged write is followed by the interrupt
    assert_irq_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ack) |=> irq);
    // R4: during the interrupt, last_ptr names the slot just written
    assert_last_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (last_ptr == $past(mem_addr)));
    // R6: no acceptance into a full ring
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready) |-> !ring_full);
endmodule

// File: tb/evt_ring_producer_tb.sv
module evt_ring_producer_tb;
    localparam int PW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] ring_len = 4'd5;
    logic          evt_valid = 1'b0;
    logic [DW-1:0] evt_data = '0;
    logic          evt_ready;
    logic          db_valid = 1'b0;
    logic [PW-1:0] db_wp = '0;
    logic          mem_we;
    logic [PW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack;
    logic          irq;
    logic [PW-1:0] rd_ptr, wr_ptr, last_ptr;
    logic          ring_full, ring_empty;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    evt_ring_producer #(.PTR_W(PW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ring_len(ring_len),
        .evt_valid(evt_valid), .evt_data(evt_data), .evt_ready(evt_ready),
        .db_valid(db_valid), .db_wp(db_wp),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .irq(irq), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .last_ptr(last_ptr),
        .ring_full(ring_full), .ring_empty(ring_empty)
    );

    // ring memory model: acknowledge one edge after a request is seen
    logic [DW-1:0] mem [16];
    logic          ack_q;
    assign mem_ack = ack_q;
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= mem_we && !ack_q;
        if (rst_n && mem_we && !ack_q) mem[mem_addr] <= mem_wdata;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d exp<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic          is_db;
        logic [7:0]    val;
        logic [PW-1:0] slot;
        logic [PW-1:0] e_rp;
        logic [PW-1:0] e_wp;
        logic          e_full;
        logic          e_empty;
    } vec_t;

    // ring_len = 5; reset gives rd=0, wr=4 (empty)
    localparam vec_t VECS [10] = '{
        '{1'b0, 8'hA1, 4'd0, 4'd1, 4'd4, 1'b0, 1'b0},
        '{1'b0, 8'hB2, 4'd1, 4'd2, 4'd4, 1'b0, 1'b0},
        '{1'b0, 8'hC3, 4'd2, 4'd3, 4'd4, 1'b0, 1'b0},
        '{1'b0, 8'hD4, 4'd3, 4'd4, 4'd4, 1'b1, 1'b0},
        '{1'b1, 8'h01, 4'd0, 4'd4, 4'd1, 1'b0, 1'b0},
        '{1'b0, 8'hE5, 4'd4, 4'd0, 4'd1, 1'b0, 1'b0},
        '{1'b0, 8'hF6, 4'd0, 4'd1, 4'd1, 1'b1, 1'b0},
        '{1'b1, 8'h00, 4'd0, 4'd1, 4'd0, 1'b0, 1'b1},
        '{1'b1, 8'h07, 4'd0, 4'd1, 4'd0, 1'b0, 1'b1},
        '{1'b0, 8'h17, 4'd1, 4'd2, 4'd0, 1'b0, 1'b0}
    };

    task automatic post(input logic [DW-1:0] d, input int slot, input int exp_rp);
        int w;
        @(negedge clk);
        evt_valid = 1'b1;
        evt_data  = d;
        w = 0;
        while (!evt_ready && w < 50) begin
            @(negedge clk);
            w++;
        end
        @(negedge clk);
        evt_valid = 1'b0;
        chk("R9 ready low in flight", int'(evt_ready), 0);
        chk("R3 write request", int'(mem_we), 1);
        chk("R3 write slot", int'(mem_addr), slot);
        w = 0;
        while (!irq && w < 20) begin
            @(negedge clk);
            w++;
        end
        chk("R5 irq delay from accept", w, 2);
        chk("R4 rd_ptr advanced", int'(rd_ptr), exp_rp);
        chk("R4 last_ptr", int'(last_ptr), slot);
        chk("R3 memory content", int'(mem[slot]), int'(d));
        @(negedge clk);
        chk("R5 irq single cycle", int'(irq), 0);
    endtask

    task automatic ring_db(input logic [PW-1:0] v);
        @(negedge clk);
        db_valid = 1'b1;
        db_wp    = v;
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_ptr in reset", int'(rd_ptr), 0);
        chk("R1 wr_ptr in reset", int'(wr_ptr), 4);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 empty", int'(ring_empty), 1);
        chk("R1 full", int'(ring_full), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 mem_we", int'(mem_we), 0);
        chk("R1 ready", int'(evt_ready), 1);

        // table walk: R2 R3 R4 R5 R7 R8
        for (int i = 0; i < 10; i++) begin
            if (VECS[i].is_db) ring_db(VECS[i].val[PW-1:0]);
            else post({24'h5A5A00, VECS[i].val}, int'(VECS[i].slot), int'(VECS[i].e_rp));
            chk("R8 rd_ptr", int'(rd_ptr), int'(VECS[i].e_rp));
            chk("R7 wr_ptr", int'(wr_ptr), int'(VECS[i].e_wp));
            chk("R2 full flag", int'(ring_full), int'(VECS[i].e_full));
            chk("R2 empty flag", int'(ring_empty), int'(VECS[i].e_empty));
        end

        // fill to full: rd 2->3->4->0 with wr=0
        post(32'h1000_0002, 2, 3);
        post(32'h1000_0003, 3, 4);
        post(32'h1000_0004, 4, 0);
        chk("R2 full after fill", int'(ring_full), 1);

        // R6: held event while full is not accepted
        @(negedge clk);
        evt_valid = 1'b1;
        evt_data  = 32'hDEAD_BEEF;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (evt_ready || mem_we) chk("R6 blocked while full", 1, 0);
        end
        chk("R6 rd_ptr held", int'(rd_ptr), 0);
        chk("R6 ready low", int'(evt_ready), 0);
        evt_valid = 1'b0;

        // free two slots, then the next event lands at slot 0
        ring_db(4'd2);
        chk("R6 not full after doorbell", int'(ring_full), 0);
        post(32'hDEAD_BEEF, 0, 1);

        // R1 again after a mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_ptr after reset", int'(rd_ptr), 0);
        chk("R1 wr_ptr after reset", int'(wr_ptr), 4);
        chk("R1 empty after reset", int'(ring_empty), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule